// File: doc/BRIEF.md
# Synthesizer Feedback Divider and Status Pin Selector

This block holds the digital counting chain of an integer-N frequency synthesizer. A strobe at oscillator rate enters a prescaler that cannot be bypassed. The prescaler's terminal pulse serves as the tick of the clock distribution bus and also drives an 18-bit feedback counter. The total feedback ratio is therefore the feedback value times the prescaler ratio, and the oscillator settles at reference × N × prescaler / R. A separate 12-bit counter divides reference-rate strobes. Everything runs on one system clock. The oscillator and reference edges arrive as single-cycle enable strobes.

A 4-bit selector drives one multipurpose status pin, modelled as a registered value plus an output enable. The pin can show a constant, the digital lock indication in either polarity, the analog lock indication (push-pull, or open-drain in either sense), the terminal pulse of either counter, or that pulse halved into a square wave. When a divider setting is illegal, that counter stops where it is and raises its error bit instead of pulsing. A changed divider value is picked up at the next terminal count, so no period is ever cut short.

Top module: `pll_fb_div`

## Requirements
- R1: While reset is asserted, busTick, statusOut, statusOe and all cfgErr bits are 0.
- R2: With presCode from 2 to 8, busTick pulses for exactly one clock once every presCode accepted vcoTick strobes. The first accepted strobe after reset produces a pulse. Two pulses are never on consecutive clocks.
- R3: presCode values 0, 1 and 9 to 15 are illegal. The prescaler then ignores vcoTick, busTick stays 0, and cfgErr[0] is 1 from the next clock on.
- R4: The feedback counter counts busTick pulses and gives one terminal pulse every nValue pulses, for nValue from 1 to 262143. nValue 0 stops it and sets cfgErr[1].
- R5: The reference counter counts refTick strobes and gives one terminal pulse every rValue strobes, for rValue from 1 to 4095. rValue 0 stops it and sets cfgErr[2].
- R6: A divider value that changes mid-period takes effect only after the current period completes.
- R7: The pin code is pinSel. Code 0 and codes 12 to 15 give statusOe 0 and statusOut 0. Code 1 drives 1. Code 2 drives 0.
- R8: Code 3 drives digLock. Code 4 drives its inverse. Code 5 drives anaLock push-pull.
- R9: Code 6 is a pull-down open drain: statusOut is 0 and statusOe equals NOT anaLock. Code 7 is a pull-up open drain: statusOut is 1 and statusOe equals anaLock.
- R10: Code 8 shows the feedback terminal pulse and code 10 the reference terminal pulse. Codes 9 and 11 show a square wave that starts low after reset and toggles once per terminal pulse of the feedback or reference counter.
- R11: The status pin is registered. It reflects the inputs and counter state one clock after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vcoTick | input | 1 | One-cycle strobe per oscillator edge |
| refTick | input | 1 | One-cycle strobe per reference edge |
| presCode | input | 4 | Prescaler ratio code |
| nValue | input | 18 | Feedback divide value |
| rValue | input | 12 | Reference divide value |
| pinSel | input | 4 | Status pin function code |
| digLock | input | 1 | Digital lock indication |
| anaLock | input | 1 | Analog lock indication |
| busTick | output | 1 | Prescaler terminal pulse for the distribution bus |
| statusOut | output | 1 | Status pin data value |
| statusOe | output | 1 | Status pin drive enable |
| cfgErr | output | 3 | Illegal setting flags: bit0 prescaler, bit1 feedback, bit2 reference |

## Verification
The assertions assume that pinSel and the lock inputs are sampled at a clock edge and held to the next edge. Those values are then compared one clock later with the registered pin. The assertions also assume that busTick and cfgErr[0] are derived from the same sampled prescaler code. The stimulus changes inputs only on the falling clock edge, so every input is stable for a full cycle. Configurations change at random moments, including mid-period and to illegal codes, to exercise the deferred reload and the hold behaviour.

// File: rtl/pll_fb_pkg.sv
package pll_fb_pkg;

  // run enables issued by the control unit to the counters
  typedef struct packed {
    logic presRun;
    logic nRun;
    logic rRun;
  } runStrb_t;

  // status pin function codes
  localparam logic [3:0] SEL_OFF    = 4'd0;
  localparam logic [3:0] SEL_HIGH   = 4'd1;
  localparam logic [3:0] SEL_LOW    = 4'd2;
  localparam logic [3:0] SEL_DLOCK  = 4'd3;
  localparam logic [3:0] SEL_DLOCKN = 4'd4;
  localparam logic [3:0] SEL_ALOCK  = 4'd5;
  localparam logic [3:0] SEL_ODN    = 4'd6;
  localparam logic [3:0] SEL_ODP    = 4'd7;
  localparam logic [3:0] SEL_NPULSE = 4'd8;
  localparam logic [3:0] SEL_NHALF  = 4'd9;
  localparam logic [3:0] SEL_RPULSE = 4'd10;
  localparam logic [3:0] SEL_RHALF  = 4'd11;

endpackage

// File: rtl/pll_fb_divcnt.sv
module pll_fb_divcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic [W-1:0] reloadVal,
  output logic         tc
);
  logic [W-1:0] cnt;

  // down counter: terminal at zero, reload picks up the newest value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      tc  <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (run) begin
        if (cnt == '0) begin
          cnt <= reloadVal;
          tc  <= 1'b1;
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pll_fb_ctrl.sv
module pll_fb_ctrl
  import pll_fb_pkg::*;
#(
  parameter int PRES_W   = 4,
  parameter int N_W      = 18,
  parameter int R_W      = 12,
  parameter int PRES_MIN = 2,
  parameter int PRES_MAX = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vcoTick,
  input  logic              refTick,
  input  logic              busTick,
  input  logic [PRES_W-1:0] presCode,
  input  logic [N_W-1:0]    nValue,
  input  logic [R_W-1:0]    rValue,
  output runStrb_t          strb,
  output logic [2:0]        cfgErr
);
  logic presOk, nOk, rOk;

  always_comb begin
    presOk = (presCode >= PRES_W'(PRES_MIN)) && (presCode <= PRES_W'(PRES_MAX));
    nOk    = |nValue;
    rOk    = |rValue;
    strb.presRun = vcoTick & presOk;
    strb.nRun    = busTick & nOk;
    strb.rRun    = refTick & rOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= '0;
    else       cfgErr <= {~rOk, ~nOk, ~presOk};
  end
endmodule

// File: rtl/pll_fb_dp.sv
module pll_fb_dp
  import pll_fb_pkg::*;
#(
  parameter int PRES_W = 4,
  parameter int N_W    = 18,
  parameter int R_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  runStrb_t          strb,
  input  logic [PRES_W-1:0] presCode,
  input  logic [N_W-1:0]    nValue,
  input  logic [R_W-1:0]    rValue,
  output logic              busTick,
  output logic              nTc,
  output logic              rTc,
  output logic              nHalf,
  output logic              rHalf
);
  logic [PRES_W-1:0] presReload;
  logic [N_W-1:0]    nReload;
  logic [R_W-1:0]    rReload;

  assign presReload = presCode - PRES_W'(1);
  assign nReload    = nValue - N_W'(1);
  assign rReload    = rValue - R_W'(1);

  pll_fb_divcnt #(.W(PRES_W)) presCnt_i (
    .clk(clk), .rstN(rstN), .run(strb.presRun), .reloadVal(presReload), .tc(busTick));

  pll_fb_divcnt #(.W(N_W)) nCnt_i (
    .clk(clk), .rstN(rstN), .run(strb.nRun), .reloadVal(nReload), .tc(nTc));

  pll_fb_divcnt #(.W(R_W)) rCnt_i (
    .clk(clk), .rstN(rstN), .run(strb.rRun), .reloadVal(rReload), .tc(rTc));

  // halved square waves
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nHalf <= 1'b0;
      rHalf <= 1'b0;
    end else begin
      nHalf <= nHalf ^ nTc;
      rHalf <= rHalf ^ rTc;
    end
  end
endmodule

// File: rtl/pll_fb_pinmux.sv
module pll_fb_pinmux
  import pll_fb_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] pinSel,
  input  logic             digLock,
  input  logic             anaLock,
  input  logic             nTc,
  input  logic             nHalf,
  input  logic             rTc,
  input  logic             rHalf,
  output logic             pinOut,
  output logic             pinOe
);
  logic nxtOut, nxtOe;

  always_comb begin
    nxtOut = 1'b0;
    nxtOe  = 1'b1;
    case (4'(pinSel))
      SEL_HIGH:   nxtOut = 1'b1;
      SEL_LOW:    nxtOut = 1'b0;
      SEL_DLOCK:  nxtOut = digLock;
      SEL_DLOCKN: nxtOut = ~digLock;
      SEL_ALOCK:  nxtOut = anaLock;
      SEL_ODN:    nxtOe  = ~anaLock;
      SEL_ODP: begin
        nxtOut = 1'b1;
        nxtOe  = anaLock;
      end
      SEL_NPULSE: nxtOut = nTc;
      SEL_NHALF:  nxtOut = nHalf;
      SEL_RPULSE: nxtOut = rTc;
      SEL_RHALF:  nxtOut = rHalf;
      default:    nxtOe  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinOut <= 1'b0;
      pinOe  <= 1'b0;
    end else begin
      pinOut <= nxtOut;
      pinOe  <= nxtOe;
    end
  end
endmodule

// File: rtl/pll_fb_div.sv
module pll_fb_div
  import pll_fb_pkg::*;
#(
  parameter int PRES_W   = 4,
  parameter int N_W      = 18,
  parameter int R_W      = 12,
  parameter int SEL_W    = 4,
  parameter int PRES_MIN = 2,
  parameter int PRES_MAX = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vcoTick,
  input  logic              refTick,
  input  logic [PRES_W-1:0] presCode,
  input  logic [N_W-1:0]    nValue,
  input  logic [R_W-1:0]    rValue,
  input  logic [SEL_W-1:0]  pinSel,
  input  logic              digLock,
  input  logic              anaLock,
  output logic              busTick,
  output logic              statusOut,
  output logic              statusOe,
  output logic [2:0]        cfgErr
);
  runStrb_t strb;
  logic nTc, rTc, nHalf, rHalf;

  pll_fb_ctrl #(.PRES_W(PRES_W), .N_W(N_W), .R_W(R_W),
                .PRES_MIN(PRES_MIN), .PRES_MAX(PRES_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN), .vcoTick(vcoTick), .refTick(refTick), .busTick(busTick),
    .presCode(presCode), .nValue(nValue), .rValue(rValue), .strb(strb), .cfgErr(cfgErr));

  pll_fb_dp #(.PRES_W(PRES_W), .N_W(N_W), .R_W(R_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .presCode(presCode), .nValue(nValue),
    .rValue(rValue), .busTick(busTick), .nTc(nTc), .rTc(rTc), .nHalf(nHalf), .rHalf(rHalf));

  pll_fb_pinmux #(.SEL_W(SEL_W)) pin_i (
    .clk(clk), .rstN(rstN), .pinSel(pinSel), .digLock(digLock), .anaLock(anaLock),
    .nTc(nTc), .nHalf(nHalf), .rTc(rTc), .rHalf(rHalf), .pinOut(statusOut), .pinOe(statusOe));
endmodule

// File: rtl/pll_fb_div_chk.sv
module pll_fb_div_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             busTick,
  input logic [2:0]       cfgErr,
  input logic [SEL_W-1:0] pinSel,
  input logic             digLock,
  input logic             statusOut,
  input logic             statusOe
);
  logic seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  p_bus_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    busTick |=> !busTick);

  p_hold_on_invalid_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr[0] |-> !busTick);

  p_pin_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (seen && ($past(pinSel) == 0 || $past(pinSel) >= 12)) |-> !statusOe);

  p_pin_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(pinSel) == 1) |-> (statusOut && statusOe));

  p_dlock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(pinSel) == 3) |-> (statusOe && statusOut == $past(digLock)));

  p_od_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(pinSel) == 6) |-> !statusOut);

  p_od_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(pinSel) == 7) |-> statusOut);
endmodule

bind pll_fb_div pll_fb_div_chk #(.SEL_W(SEL_W)) chk_i (
  .clk(clk), .rstN(rstN), .busTick(busTick), .cfgErr(cfgErr), .pinSel(pinSel),
  .digLock(digLock), .statusOut(statusOut), .statusOe(statusOe));

// File: tb/pll_fb_div_tb.sv
`timescale 1ns/1ps
module pll_fb_div_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vcoTick = 1'b0, refTick = 1'b0, digLock = 1'b0, anaLock = 1'b0;
  logic [3:0]  presCode = 4'd4;
  logic [17:0] nValue = 18'd3;
  logic [11:0] rValue = 12'd5;
  logic [3:0]  pinSel = 4'd0;
  logic        busTick, statusOut, statusOe;
  logic [2:0]  cfgErr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit cmpEn = 0;

  always #4 clk = ~clk;

  pll_fb_div dut_i (
    .clk(clk), .rstN(rstN), .vcoTick(vcoTick), .refTick(refTick), .presCode(presCode),
    .nValue(nValue), .rValue(rValue), .pinSel(pinSel), .digLock(digLock), .anaLock(anaLock),
    .busTick(busTick), .statusOut(statusOut), .statusOe(statusOe), .cfgErr(cfgErr));

  // reference model state
  int   mPres, mN, mR;
  logic mBus, mNTc, mRTc, mNHalf, mRHalf, mOut, mOe;
  logic [2:0] mErr;
  logic [3:0] mSel;

  function automatic logic [1:0] pinFn(input logic [3:0] s, input logic dl, input logic al,
                                       input logic ntc, input logic nh, input logic rtc, input logic rh);
    case (s)
      4'd1: return 2'b11;
      4'd2: return 2'b10;
      4'd3: return {1'b1, dl};
      4'd4: return {1'b1, ~dl};
      4'd5: return {1'b1, al};
      4'd6: return {~al, 1'b0};
      4'd7: return {al, 1'b1};
      4'd8: return {1'b1, ntc};
      4'd9: return {1'b1, nh};
      4'd10: return {1'b1, rtc};
      4'd11: return {1'b1, rh};
      default: return 2'b00;
    endcase
  endfunction

  function automatic string reqOfSel(input logic [3:0] s);
    if (s == 0 || s == 1 || s == 2 || s >= 12) return "R7";
    if (s <= 5) return "R8";
    if (s <= 7) return "R9";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPres = 0; mN = 0; mR = 0;
      mBus = 0; mNTc = 0; mRTc = 0; mNHalf = 0; mRHalf = 0;
      mOut = 0; mOe = 0; mErr = 0; mSel = 0;
    end else begin
      logic presOk, nOk, rOk, nb, nn, nr;
      logic [1:0] p;
      presOk = presCode >= 2 && presCode <= 8;
      nOk = nValue != 0;
      rOk = rValue != 0;
      nb = 0; nn = 0; nr = 0;
      if (presOk && vcoTick) begin
        if (mPres == 0) begin mPres = int'(presCode) - 1; nb = 1; end else mPres = mPres - 1;
      end
      if (nOk && mBus) begin
        if (mN == 0) begin mN = int'(nValue) - 1; nn = 1; end else mN = mN - 1;
      end
      if (rOk && refTick) begin
        if (mR == 0) begin mR = int'(rValue) - 1; nr = 1; end else mR = mR - 1;
      end
      p = pinFn(pinSel, digLock, anaLock, mNTc, mNHalf, mRTc, mRHalf);
      mOe = p[1]; mOut = p[0]; mSel = pinSel;
      mNHalf = mNHalf ^ mNTc;
      mRHalf = mRHalf ^ mRTc;
      mErr = {~rOk, ~nOk, ~presOk};
      mBus = nb; mNTc = nn; mRTc = nr;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && cmpEn && !done) begin
      check(busTick == mBus, "R2", "busTick", busTick, mBus);
      check(cfgErr == mErr, "R3", "cfgErr", cfgErr, mErr);
      check({statusOe, statusOut} == {mOe, mOut}, reqOfSel(mSel), "pin{oe,out}",
            {statusOe, statusOut}, {mOe, mOut});
    end
  end

  task automatic countHigh(input int cycles, input bit usePin, output int cnt);
    cnt = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (usePin ? statusOut : busTick) cnt++;
    end
  endtask

  task automatic gapToBus(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!busTick && gap < 100);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c, g1, g2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busTick == 0 && statusOut == 0 && statusOe == 0 && cfgErr == 0, "R1", "reset outputs",
          {busTick, statusOut, statusOe, cfgErr}, 0);
    rstN = 1'b1;
    cmpEn = 1;
    vcoTick = 1; refTick = 1; pinSel = 4'd8;
    repeat (60) @(negedge clk);
    // R2 prescaler by 4
    countHigh(40, 0, c);
    check(c == 10, "R2", "bus pulses in 40 ticks, div 4", c, 10);
    // R4 total feedback 4*3 = 12
    countHigh(120, 1, c);
    check(c == 10, "R4", "feedback pulses in 120 ticks", c, 10);
    // R5 reference by 5
    @(negedge clk); pinSel = 4'd10;
    repeat (20) @(negedge clk);
    countHigh(50, 1, c);
    check(c == 10, "R5", "reference pulses in 50 ticks", c, 10);
    // R10 halved wave: prescaler 2, feedback 1 -> period 4
    @(negedge clk); presCode = 4'd2; nValue = 18'd1; pinSel = 4'd9;
    repeat (30) @(negedge clk);
    countHigh(40, 1, c);
    check(c == 20, "R10", "halved high cycles in 40", c, 20);
    // R6 deferred reload of the prescaler
    @(negedge clk); presCode = 4'd8;
    repeat (30) @(negedge clk);
    gapToBus(g1);
    presCode = 4'd2;
    gapToBus(g1);
    gapToBus(g2);
    check(g1 == 8, "R6", "gap after change", g1, 8);
    check(g2 == 2, "R6", "gap with new value", g2, 2);
    // R3 illegal prescaler
    @(negedge clk); presCode = 4'd9;
    @(negedge clk);
    countHigh(20, 0, c);
    check(c == 0, "R3", "bus pulses with illegal code", c, 0);
    check(cfgErr[0] == 1, "R3", "prescaler error flag", cfgErr[0], 1);
    // R4/R5 zero values
    presCode = 4'd3; nValue = 18'd0; rValue = 12'd0;
    repeat (2) @(negedge clk);
    check(cfgErr == 3'b110, "R4", "zero feedback/reference flags", cfgErr, 6);
    pinSel = 4'd10;
    repeat (2) @(negedge clk);
    countHigh(20, 1, c);
    check(c == 0, "R5", "no reference pulses when zero", c, 0);
    // R8 inverted digital lock, R11 latency
    nValue = 18'd2; rValue = 12'd3; digLock = 1; pinSel = 4'd4;
    @(negedge clk);
    @(negedge clk);
    check(statusOe == 1 && statusOut == 0, "R8", "inverted lock", {statusOe, statusOut}, 2);
    pinSel = 4'd1;
    @(negedge clk);
    check(statusOut == 1, "R11", "pin after one clock", statusOut, 1);
    // R9 open drain pull-down with lock low
    anaLock = 0; pinSel = 4'd6;
    @(negedge clk);
    check(statusOe == 1 && statusOut == 0, "R9", "open drain low", {statusOe, statusOut}, 2);
    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      vcoTick = ($urandom % 10) < 7;
      refTick = ($urandom % 10) < 4;
      digLock = $urandom % 2;
      anaLock = $urandom % 2;
      if ($urandom % 40 == 0) presCode = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'(2 + $urandom % 7);
      if ($urandom % 40 == 0) nValue = 18'($urandom % 7);
      if ($urandom % 60 == 0) nValue = 18'(262100 + $urandom % 44);
      if ($urandom % 40 == 0) rValue = 12'($urandom % 9);
      if ($urandom % 25 == 0) pinSel = 4'($urandom % 16);
    end
    @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule